// File: doc/BRIEF.md
# SDRAM Burst Page-Mode Sequencer

This block turns a single host transfer request into the command stream for one 16-bit SDRAM device with four banks. On acceptance it opens the addressed row, issues one column command per data word on consecutive clocks, and closes all banks with a precharge-all when the transfer ends. The device's own burst logic is assumed to be set to a burst length of one. The sequencer generates every column address itself, so a transfer wider than the data port becomes a run of single-word READ or WRITE commands inside one open row.

The host side is a level request with a write flag, a byte address, a size code and a line-wide data bus in each direction. The host holds the request until it sees the one-cycle acknowledge. For reads, the block counts out the programmed CAS latency and captures each returned word. It packs the words into the read-data bus and acknowledges after the last word is captured. For writes it drives each word on the data pins in the same cycle as its WRITE command. Refresh, mode-register setup and chip-select decoding for several devices belong to other logic.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is high and after it is released with no request, the pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), sd_dq_oe is 0 and ack_o is 0.
- R2: In the cycle after a request is sampled in idle, the pins carry ACTIVATE (0011), sd_ba carries address bits [10:9] and sd_addr carries address bits [22:11]. Bit 0 of the byte address is the byte lane and bits [8:1] are the column.
- R3: Column commands start the cycle right after ACTIVATE and run on consecutive cycles. Beat i carries column base+i on sd_addr[7:0], keeps sd_addr[10] low and keeps the bank of the ACTIVATE.
- R4: The number of column commands is 1 for size code 0 (1 byte) and 1 (2 bytes), 2 for code 2 (4 bytes), and 8 for code 3 (16 bytes).
- R5: Each WRITE (0100) drives wdata bits [16i+15:16i] on sd_dq_o for beat i with sd_dq_oe high. sd_dq_oe is low in every other cycle.
- R6: A size-0 write drives the byte wdata[7:0] on both lanes and sets sd_dqm to 2'b10 when address bit 0 is 0 and to 2'b01 when it is 1. Other writes and all reads use sd_dqm = 2'b00.
- R7: Each READ (0101) has its word sampled on sd_dq_i CAS_LAT+1 clock edges after the command appears. Word i lands in rdata_o bits [16i+15:16i] and unused upper bits are zero. A size-0 read returns DQ[7:0] or DQ[15:8] (address bit 0 = 0 or 1) in rdata_o[7:0].
- R8: After the last READ, NOP is issued for CAS_LAT cycles. PRECHARGE (0010) with sd_addr[10] high follows in the cycle after the last word is captured.
- R9: After the last WRITE, the next cycle carries PRECHARGE with sd_addr[10] high.
- R10: ack_o is high for exactly one cycle, the cycle of the closing PRECHARGE, and rdata_o holds the complete read result in that cycle.
- R11: Changes to request inputs while a transfer runs, and a request still held in the acknowledge cycle, have no effect. The cycle after the acknowledge carries NOP when the request is then dropped.
- R12: Address bits below the transfer's own alignment (beats-1 in the column field) are ignored, so the column base is aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Transfer request, held until ack_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 23 | Byte address {row, bank, column, lane} |
| size_i | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=16B |
| wdata_i | input | 128 | Write data, beat i in bits [16i+15:16i] |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 128 | Read result, valid with ack_o |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed row/column address, bit 10 = precharge-all flag |
| sd_dqm | output | 2 | Byte masks, active high |
| sd_dq_o | output | 16 | Data to the device |
| sd_dq_oe | output | 1 | Output enable for sd_dq_o |
| sd_dq_i | input | 16 | Data from the device |

## Verification
Counting from the clock edge that accepts a request, ACTIVATE is due after edge 0 and beat i after edge 1+i. A write's precharge and acknowledge are due after edge N+1 for N beats. A read's precharge and acknowledge are due after edge N+CAS_LAT+1, with NOPs in between. The bench drives inputs and samples every pin on the falling edge. It walks through exactly these cycle slots for each transfer, and a small device model answers each READ it sees with an address-derived word two edges later. The bench predicts that word from the same address function.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } sd_cmd_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LINE = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BURST  = 2'd1,
    ST_RDWAIT = 2'd2,
    ST_WRPRE  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W      = 12,
  parameter int COL_W      = 8,
  parameter int BANK_W     = 2,
  parameter int LANE_W     = 1,
  parameter int LINE_BYTES = 16,
  parameter int BEAT_CW    = 4,
  parameter int ADDR_W     = 23
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  xfer_size_e         size_i,
  output logic [ROW_W-1:0]   row_o,
  output logic [BANK_W-1:0]  bank_o,
  output logic [COL_W-1:0]   col_o,
  output logic [LANE_W-1:0]  lane_o,
  output logic [BEAT_CW-1:0] beats_o,
  output logic               byte_o
);
  localparam int BPW = 1 << LANE_W;

  int unsigned nbytes;
  int unsigned nbeats;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: nbytes = 1;
      SZ_HALF: nbytes = 2;
      SZ_WORD: nbytes = 4;
      default: nbytes = LINE_BYTES;
    endcase
    nbeats = nbytes / BPW;
    if (nbeats == 0) nbeats = 1;
    beats_o = BEAT_CW'(nbeats);
    // column base aligned to the burst length
    col_o   = addr_i[LANE_W +: COL_W] & ~COL_W'(nbeats - 1);
    bank_o  = addr_i[LANE_W + COL_W +: BANK_W];
    row_o   = addr_i[LANE_W + COL_W + BANK_W +: ROW_W];
    lane_o  = addr_i[LANE_W-1:0];
    byte_o  = (size_i == SZ_BYTE);
  end

endmodule

// File: rtl/sdram_beat_gen.sv
module sdram_beat_gen #(
  parameter int COL_W   = 8,
  parameter int BEAT_CW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [COL_W-1:0]   col_base_i,
  input  logic [BEAT_CW-1:0] beats_i,
  output logic [COL_W-1:0]   col_o,
  output logic [BEAT_CW-1:0] idx_o,
  output logic               last_o
);
  logic [COL_W-1:0]   base_q;
  logic [BEAT_CW-1:0] total_q;
  logic [BEAT_CW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      total_q <= '0;
      idx_q   <= '0;
    end else if (load_i) begin
      base_q  <= col_base_i;
      total_q <= beats_i;
      idx_q   <= '0;
    end else if (step_i) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign col_o  = base_q + COL_W'(idx_q);
  assign idx_o  = idx_q;
  assign last_o = (idx_q == total_q - 1'b1);

  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (rst)
    step_i |-> (idx_q < total_q)) else $error("beat index beyond count"); // R4

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DQ_W      = 16,
  parameter int MAX_BEATS = 8,
  parameter int BEAT_CW   = 4,
  parameter int LANE_W    = 1,
  parameter int CAS_LAT   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [BEAT_CW-1:0]        beats_i,
  input  logic                      byte_i,
  input  logic [LANE_W-1:0]         lane_i,
  input  logic                      rd_issue_i,
  input  logic [DQ_W-1:0]           dq_i,
  output logic [MAX_BEATS*DQ_W-1:0] rdata_o,
  output logic                      last_o
);
  logic [CAS_LAT:1]   lat_sh;
  logic [BEAT_CW-1:0] beats_q;
  logic [BEAT_CW-1:0] cnt_q;
  logic               byte_q;
  logic [LANE_W-1:0]  lane_q;
  logic               capture;
  logic [DQ_W-1:0]    cap_word;
  logic [DQ_W-1:0]    words_q [MAX_BEATS];

  // latency line: one stage per clock after the READ leaves the pins
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_sh <= '0;
    end else begin
      lat_sh[1] <= rd_issue_i;
      for (int i = 2; i <= CAS_LAT; i++) lat_sh[i] <= lat_sh[i-1];
    end
  end

  assign capture  = lat_sh[CAS_LAT];
  assign cap_word = byte_q ? DQ_W'(dq_i[{lane_q, 3'b000} +: 8]) : dq_i;
  assign last_o   = capture && (cnt_q == beats_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      beats_q <= '0;
      cnt_q   <= '0;
      byte_q  <= 1'b0;
      lane_q  <= '0;
    end else if (start_i) begin
      beats_q <= beats_i;
      cnt_q   <= '0;
      byte_q  <= byte_i;
      lane_q  <= lane_i;
    end else if (capture) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst || start_i) begin
        words_q[g] <= '0;
      end else if (capture && cnt_q == BEAT_CW'(g)) begin
        words_q[g] <= cap_word;
      end
    end
    assign rdata_o[g*DQ_W +: DQ_W] = words_q[g];
  end

  AST_CAP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    capture |-> (cnt_q < beats_q)) else $error("capture beyond beat count"); // R7

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter  int ROW_W      = 12,
  parameter  int COL_W      = 8,
  parameter  int BANK_W     = 2,
  parameter  int DQ_W       = 16,
  parameter  int LINE_BYTES = 16,
  parameter  int CAS_LAT    = 2,
  parameter  int AP_BIT     = 10,
  localparam int BPW        = DQ_W / 8,
  localparam int LANE_W     = $clog2(BPW),
  localparam int MAX_BEATS  = LINE_BYTES / BPW,
  localparam int BEAT_CW    = $clog2(MAX_BEATS + 1),
  localparam int LINE_W     = LINE_BYTES * 8,
  localparam int ADDR_W     = ROW_W + BANK_W + COL_W + LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [LINE_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [LINE_W-1:0] rdata_o,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BPW-1:0]    sd_dqm,
  output logic [DQ_W-1:0]   sd_dq_o,
  output logic              sd_dq_oe,
  input  logic [DQ_W-1:0]   sd_dq_i
);
  seq_state_e         state_q;
  sd_cmd_e            cmd_q;
  logic [BANK_W-1:0]  ba_q;
  logic [ROW_W-1:0]   addr_q;
  logic [BPW-1:0]     dqm_q;
  logic [DQ_W-1:0]    dq_o_q;
  logic               oe_q;
  logic               ack_q;
  logic               rd_iss_q;
  logic               we_q;
  logic               byte_q;
  logic [LANE_W-1:0]  lane_q;
  logic [LINE_W-1:0]  wdata_q;

  logic [ROW_W-1:0]   sp_row;
  logic [BANK_W-1:0]  sp_bank;
  logic [COL_W-1:0]   sp_col;
  logic [LANE_W-1:0]  sp_lane;
  logic [BEAT_CW-1:0] sp_beats;
  logic               sp_byte;

  logic [COL_W-1:0]   col_cur;
  logic [BEAT_CW-1:0] beat_idx;
  logic               beat_last;
  logic               cap_last;
  logic               accept;
  logic               in_burst;
  logic [DQ_W-1:0]    wbeat;
  logic [BPW-1:0]     wmask;

  assign accept   = (state_q == ST_IDLE) && req_i && !ack_q;
  assign in_burst = (state_q == ST_BURST);

  sdram_addr_split #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .LANE_W(LANE_W),
    .LINE_BYTES(LINE_BYTES), .BEAT_CW(BEAT_CW), .ADDR_W(ADDR_W)
  ) u_split (
    .addr_i (addr_i),
    .size_i (xfer_size_e'(size_i)),
    .row_o  (sp_row),
    .bank_o (sp_bank),
    .col_o  (sp_col),
    .lane_o (sp_lane),
    .beats_o(sp_beats),
    .byte_o (sp_byte)
  );

  sdram_beat_gen #(.COL_W(COL_W), .BEAT_CW(BEAT_CW)) u_beat (
    .clk       (clk),
    .rst       (rst),
    .load_i    (accept),
    .step_i    (in_burst),
    .col_base_i(sp_col),
    .beats_i   (sp_beats),
    .col_o     (col_cur),
    .idx_o     (beat_idx),
    .last_o    (beat_last)
  );

  sdram_rd_capture #(
    .DQ_W(DQ_W), .MAX_BEATS(MAX_BEATS), .BEAT_CW(BEAT_CW),
    .LANE_W(LANE_W), .CAS_LAT(CAS_LAT)
  ) u_cap (
    .clk       (clk),
    .rst       (rst),
    .start_i   (accept),
    .beats_i   (sp_beats),
    .byte_i    (sp_byte),
    .lane_i    (sp_lane),
    .rd_issue_i(rd_iss_q),
    .dq_i      (sd_dq_i),
    .rdata_o   (rdata_o),
    .last_o    (cap_last)
  );

  // write word for the current beat; a single byte goes out on every lane
  always_comb begin
    if (byte_q) begin
      wbeat = {BPW{wdata_q[7:0]}};
      wmask = ~(BPW'(1) << lane_q);
    end else begin
      wbeat = wdata_q[int'(beat_idx)*DQ_W +: DQ_W];
      wmask = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cmd_q    <= CMD_NOP;
      ba_q     <= '0;
      addr_q   <= '0;
      dqm_q    <= '0;
      dq_o_q   <= '0;
      oe_q     <= 1'b0;
      ack_q    <= 1'b0;
      rd_iss_q <= 1'b0;
      we_q     <= 1'b0;
      byte_q   <= 1'b0;
      lane_q   <= '0;
      wdata_q  <= '0;
    end else begin
      cmd_q    <= CMD_NOP;
      addr_q   <= '0;
      dqm_q    <= '0;
      oe_q     <= 1'b0;
      ack_q    <= 1'b0;
      rd_iss_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            we_q    <= we_i;
            byte_q  <= sp_byte;
            lane_q  <= sp_lane;
            wdata_q <= wdata_i;
            cmd_q   <= CMD_ACT;
            ba_q    <= sp_bank;
            addr_q  <= sp_row;
            state_q <= ST_BURST;
          end
        end
        ST_BURST: begin
          cmd_q    <= we_q ? CMD_WR : CMD_RD;
          addr_q   <= ROW_W'(col_cur);
          rd_iss_q <= !we_q;
          if (we_q) begin
            oe_q   <= 1'b1;
            dq_o_q <= wbeat;
            dqm_q  <= wmask;
          end
          if (beat_last) state_q <= we_q ? ST_WRPRE : ST_RDWAIT;
        end
        ST_WRPRE: begin
          cmd_q          <= CMD_PRE;
          addr_q[AP_BIT] <= 1'b1;
          ack_q          <= 1'b1;
          state_q        <= ST_IDLE;
        end
        ST_RDWAIT: begin
          if (cap_last) begin
            cmd_q          <= CMD_PRE;
            addr_q[AP_BIT] <= 1'b1;
            ack_q          <= 1'b1;
            state_q        <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba    = ba_q;
  assign sd_addr  = addr_q;
  assign sd_dqm   = dqm_q;
  assign sd_dq_o  = dq_o_q;
  assign sd_dq_oe = oe_q;
  assign ack_o    = ack_q;

  logic is_col;
  assign is_col = (cmd_q == CMD_RD) || (cmd_q == CMD_WR);

  AST_ACK_WITH_PALL: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> (cmd_q == CMD_PRE) && sd_addr[AP_BIT]) else $error("ack without precharge-all"); // R10
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    ack_q |=> !ack_q) else $error("ack longer than one cycle"); // R10
  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (cmd_q == CMD_WR)) else $error("data driven outside WRITE"); // R5
  AST_COL_AFTER_ACT: assert property (@(posedge clk) disable iff (rst)
    (is_col && !$past(is_col)) |-> ($past(cmd_q) == CMD_ACT)) else $error("burst not led by ACTIVATE"); // R3
  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    (is_col && $past(is_col)) |->
      (sd_addr[COL_W-1:0] == $past(sd_addr[COL_W-1:0]) + COL_W'(1))) else $error("column not incremented"); // R3
  AST_AP_LOW_COL: assert property (@(posedge clk) disable iff (rst)
    is_col |-> !sd_addr[AP_BIT]) else $error("A10 high on column command"); // R3
  AST_WR_PRE_NEXT: assert property (@(posedge clk) disable iff (rst)
    (($past(cmd_q) == CMD_WR) && (cmd_q != CMD_WR)) |-> (cmd_q == CMD_PRE)) else $error("write burst not closed"); // R9

endmodule

// File: tb/sdram_burst_seq_tb_top.sv
module sdram_burst_seq_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam int         CL    = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req = 1'b0;
  logic         we = 1'b0;
  logic [22:0]  addr = '0;
  logic [1:0]   size = '0;
  logic [127:0] wdata = '0;
  logic         ack;
  logic [127:0] rdata;
  logic         cs_n, ras_n, cas_n, we_n;
  logic [1:0]   ba;
  logic [11:0]  sa;
  logic [1:0]   dqm;
  logic [15:0]  dq_o, dq_i;
  logic         dq_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sdram_burst_seq dut_i (
    .clk(clk), .rst(rst), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_ba(ba), .sd_addr(sa), .sd_dqm(dqm), .sd_dq_o(dq_o), .sd_dq_oe(dq_oe),
    .sd_dq_i(dq_i)
  );

  wire [3:0] cmd = {cs_n, ras_n, cas_n, we_n};

  function automatic logic [15:0] dev_word(logic [1:0] b, logic [11:0] r, logic [7:0] c);
    return (16'(c) * 16'h0105) ^ (16'(r) * 16'h0031) ^ {b, 14'h1a3c};
  endfunction

  function automatic int beats_of(logic [1:0] sz);
    return (sz == 2'd3) ? 8 : (sz == 2'd2) ? 2 : 1;
  endfunction

  // device model: answers a READ with a data word CL edges after it sees it
  logic [11:0] open_row [4];
  logic [15:0] pipe0, pipe1;
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) open_row[i] <= '0;
      pipe0 <= '0;
      pipe1 <= '0;
    end else begin
      if (cmd == C_ACT) open_row[ba] <= sa;
      pipe0 <= (cmd == C_RD) ? dev_word(ba, open_row[ba], sa[7:0]) : 16'hdead;
      pipe1 <= pipe0;
    end
  end
  assign dq_i = pipe1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [22:0] a, input logic [1:0] sz, input logic w,
                          input logic [127:0] wd);
    logic [11:0]  row;
    logic [1:0]   bk;
    logic [7:0]   cbase;
    logic         lane;
    int           nb;
    logic [127:0] exp_rd;
    logic [15:0]  exp_dq;
    nb    = beats_of(sz);
    row   = a[22:11];
    bk    = a[10:9];
    cbase = a[8:1] & ~8'(nb - 1);
    lane  = a[0];
    exp_rd = '0;
    req = 1'b1; we = w; addr = a; size = sz; wdata = wd;
    @(negedge clk);
    chk(cmd == C_ACT, "R2", "activate command", 128'(cmd), 128'(C_ACT));
    chk(ba == bk && sa == row, "R2", "activate bank/row", 128'({ba, sa}), 128'({bk, row}));
    chk(dq_oe == 1'b0, "R5", "oe during activate", 128'(dq_oe), 128'(0));
    // scramble held inputs: must be ignored while busy
    addr = 23'($urandom); wdata = {$urandom, $urandom, $urandom, $urandom};
    size = 2'($urandom); we = 1'($urandom);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      chk(cmd == (w ? C_WR : C_RD), "R4", "column command", 128'(cmd), 128'(w ? C_WR : C_RD));
      chk(sa[7:0] == cbase + 8'(i) && !sa[10] && ba == bk, "R3",
          "column address", 128'({ba, sa}), 128'({bk, 4'h0, cbase + 8'(i)}));
      if (w) begin
        exp_dq = (sz == 2'd0) ? {wd[7:0], wd[7:0]} : wd[16*i +: 16];
        chk(dq_oe && dq_o == exp_dq, "R5", "write data", 128'({dq_oe, dq_o}), 128'({1'b1, exp_dq}));
        chk(dqm == ((sz == 2'd0) ? (lane ? 2'b01 : 2'b10) : 2'b00), "R6", "byte mask",
            128'(dqm), 128'((sz == 2'd0) ? (lane ? 2'b01 : 2'b10) : 2'b00));
      end else begin
        chk(!dq_oe && dqm == 2'b00, "R5", "oe/mask during read", 128'({dq_oe, dqm}), 128'(0));
        if (sz == 2'd0)
          exp_rd[7:0] = lane ? dev_word(bk, row, cbase)[15:8] : dev_word(bk, row, cbase)[7:0];
        else
          exp_rd[16*i +: 16] = dev_word(bk, row, cbase + 8'(i));
      end
    end
    if (!w) begin
      for (int k = 0; k < CL; k++) begin
        @(negedge clk);
        chk(cmd == C_NOP && !ack, "R8", "wait for read data", 128'({ack, cmd}), 128'(C_NOP));
      end
    end
    @(negedge clk);
    chk(cmd == C_PRE && sa[10], "R9", "precharge-all", 128'({sa[10], cmd}), 128'({1'b1, C_PRE}));
    chk(ack == 1'b1, "R10", "ack with precharge", 128'(ack), 128'(1));
    if (!w) chk(rdata == exp_rd, "R7", "read data", rdata, exp_rd);
    req = 1'b0;
    @(negedge clk);
    chk(!ack && cmd == C_NOP, "R11", "no restart after ack", 128'({ack, cmd}), 128'(C_NOP));
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(cmd == C_NOP && !dq_oe && !ack, "R1", "reset pins", 128'({ack, dq_oe, cmd}), 128'(C_NOP));
    rst = 1'b0;
    @(negedge clk);
    chk(cmd == C_NOP && !dq_oe && !ack, "R1", "idle pins", 128'({ack, dq_oe, cmd}), 128'(C_NOP));

    // directed corners
    run_xfer({12'h3a5, 2'd2, 8'hf8, 1'b0}, 2'd3, 1'b0, '0);                // line read at top of row
    run_xfer({12'h011, 2'd1, 8'h13, 1'b1}, 2'd3, 1'b0, '0);                // R12 misaligned line
    run_xfer({12'h7ff, 2'd3, 8'h40, 1'b0}, 2'd3, 1'b1,
             128'h0f0e0d0c_0b0a0908_07060504_03020100);                    // line write
    run_xfer({12'h100, 2'd0, 8'h22, 1'b0}, 2'd0, 1'b1, 128'h5a);           // byte write lane 0
    run_xfer({12'h100, 2'd0, 8'h22, 1'b1}, 2'd0, 1'b1, 128'hc3);           // byte write lane 1
    run_xfer({12'h0ab, 2'd1, 8'h07, 1'b1}, 2'd0, 1'b0, '0);                // byte read lane 1
    run_xfer({12'h0ab, 2'd1, 8'h07, 1'b0}, 2'd0, 1'b0, '0);                // byte read lane 0
    run_xfer({12'h222, 2'd2, 8'h05, 1'b0}, 2'd2, 1'b0, '0);                // R12 word, base 4
    run_xfer({12'h333, 2'd3, 8'h09, 1'b0}, 2'd2, 1'b1, 128'h1234_5678);    // word write
    run_xfer({12'h444, 2'd0, 8'hff, 1'b0}, 2'd1, 1'b0, '0);                // half read

    // constrained random
    for (int n = 0; n < 60; n++) begin
      run_xfer(23'($urandom), 2'($urandom), 1'($urandom),
               {$urandom, $urandom, $urandom, $urandom});
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual no completion expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule